// File: doc/BRIEF.md
# Channel Overcurrent and Overheat Fault Guard

This block sits between the phase-drive logic of one motor output channel and its power switches. While the channel is healthy, the requested drive bits pass straight through to the switch gates with no added latency. Two fault sources are supervised. The first is a digital overcurrent comparator output. The second is an overheat flag from the thermal sensor.

The overcurrent comparator rings when a PWM on-period starts. For that reason it is ignored for a fixed number of system clocks after every rising edge of the PWM on indicator. Once this blanking window closes, the comparator must stay high for several consecutive clocks before it counts, so single-cycle glitches are rejected. The overheat flag is level-sensitive and is never blanked.

Either qualified fault sets a sticky latch. The latch forces every drive bit off and pulls the active-low fault pin. The only way out is the chip reset, either at power-on or through a high-low-high pulse on the reset pin.

Top module: `chan_fault_guard`

## Requirements
- R1: With reset released and no fault latched, `drv_o` equals `drv_req_i` in the same cycle, bit for bit.
- R2: While `rst_n` is low, `drv_o` is all zero and `fault_n_o` is 1 (latch held clear), whatever the other inputs do.
- R3: `hot_i` high at a rising clock edge, with reset released, latches the fault at that edge. Overheat is not affected by blanking.
- R4: While the fault is latched, `drv_o` is all zero regardless of `drv_req_i`, and `fault_n_o` is 0. On the pad, 0 means the pin is pulled low and 1 means it is released.
- R5: A latched fault stays latched when `hot_i` and `oc_hit_i` return low. Only driving `rst_n` low clears it.
- R6: A rising edge of `pwm_on_i` opens a blanking window of `BLANK_CYC` clock edges. The window starts with the edge where `pwm_on_i` is first seen high after being low, and `oc_hit_i` is ignored throughout it. A `pwm_on_i` already high when reset releases counts as a rising edge.
- R7: Each new rising edge of `pwm_on_i` restarts the blanking window from its full length, even if the previous window has not finished.
- R8: Outside blanking, `oc_hit_i` latches the fault only at the `FILTER_LEN`-th consecutive edge where it is high (default 2). A low edge or a blanked edge restarts the count, so a one-cycle pulse never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on or pin reset) |
| drv_req_i | input | DRV_W | Requested switch-gate drive bits |
| pwm_on_i | input | 1 | PWM on-phase indicator from the chopper |
| oc_hit_i | input | 1 | Digital overcurrent comparator output |
| hot_i | input | 1 | Overheat flag, level-sensitive |
| drv_o | output | DRV_W | Gated switch-gate drive |
| fault_n_o | output | 1 | Fault flag, 0 = pull pad low, 1 = release |

## Verification
The bench places an overcurrent that is held across a whole blanking window. It checks that the fault appears exactly two edges after the window closes. A design with an off-by-one window length, or one that ignored the edge that opens the window, would trip a cycle early or late. A second PWM edge inside the window must push the trip back. A non-retriggering timer would fault at the original point.

Alternating one-cycle comparator pulses must never trip. A filter that fails to clear its count on a low cycle would fault there. Overheat asserted inside a blanking window, and overheat held through reset, probe whether blanking or reset wrongly gate the thermal path. The reset case also checks that reset really holds the latch clear.

// File: rtl/flt_pkg.sv
package flt_pkg;

  typedef enum logic {
    LATCH_OK   = 1'b0,
    LATCH_TRIP = 1'b1
  } latch_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/flt_blank_timer.sv
module flt_blank_timer #(
  parameter int unsigned BLANK_CYC = 688
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_on_i,
  output logic blank_o
);
  import flt_pkg::*;

  localparam int unsigned CW = cnt_width(BLANK_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYC - 1);

  logic          pwm_prev_q;
  logic [CW-1:0] left_q;
  logic          rise;

  assign rise    = pwm_on_i & ~pwm_prev_q;
  assign blank_o = rise | (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_prev_q <= 1'b0;
      left_q     <= '0;
    end else begin
      pwm_prev_q <= pwm_on_i;
      if (rise)
        left_q <= RELOAD;
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end

  // R6
  blank_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_on_i) |-> blank_o);

  // R7
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= RELOAD);

endmodule

// File: rtl/flt_oc_filter.sv
module flt_oc_filter #(
  parameter int unsigned FILTER_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_i,
  output logic trip_o
);
  import flt_pkg::*;

  generate
    if (FILTER_LEN <= 1) begin : g_direct
      assign trip_o = qual_i;
    end else begin : g_count
      localparam int unsigned HW = cnt_width(FILTER_LEN);
      localparam logic [HW-1:0] LAST = HW'(FILTER_LEN - 1);
      logic [HW-1:0] hits_q;

      assign trip_o = qual_i & (hits_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          hits_q <= '0;
        else if (!qual_i)
          hits_q <= '0;
        else if (hits_q != LAST)
          hits_q <= hits_q + 1'b1;
      end

      // R8
      glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> $past(qual_i));
    end
  endgenerate

endmodule

// File: rtl/chan_fault_guard.sv
module chan_fault_guard
  import flt_pkg::*;
#(
  parameter int unsigned DRV_W      = 4,
  parameter int unsigned BLANK_CYC  = 688,
  parameter int unsigned FILTER_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DRV_W-1:0] drv_req_i,
  input  logic             pwm_on_i,
  input  logic             oc_hit_i,
  input  logic             hot_i,
  output logic [DRV_W-1:0] drv_o,
  output logic             fault_n_o
);

  logic   blank_w;
  logic   oc_qual;
  logic   oc_trip;
  latch_t latch_q;
  latch_t latch_d;

  flt_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_on_i (pwm_on_i),
    .blank_o  (blank_w)
  );

  assign oc_qual = oc_hit_i & ~blank_w;

  flt_oc_filter #(.FILTER_LEN(FILTER_LEN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .qual_i (oc_qual),
    .trip_o (oc_trip)
  );

  always_comb begin
    latch_d = latch_q;
    if (hot_i || oc_trip)
      latch_d = LATCH_TRIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      latch_q <= LATCH_OK;
    else
      latch_q <= latch_d;
  end

  assign drv_o     = (rst_n && latch_q == LATCH_OK) ? drv_req_i : '0;
  assign fault_n_o = (latch_q == LATCH_OK);

  // R1
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n_o |-> (drv_o == drv_req_i));

  // R4
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> (drv_o == '0));

  // R3
  hot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> !fault_n_o);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |=> !fault_n_o);

endmodule

// File: tb/sim_chan_fault_guard.sv
`timescale 1ns/1ps
module sim_chan_fault_guard;

  localparam int unsigned DRV_W = 4;
  localparam int unsigned BLANK = 10;
  localparam int unsigned FLEN  = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DRV_W-1:0] drv_req_i;
  logic             pwm_on_i, oc_hit_i, hot_i;
  logic [DRV_W-1:0] drv_o;
  logic             fault_n_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  chan_fault_guard #(.DRV_W(DRV_W), .BLANK_CYC(BLANK), .FILTER_LEN(FLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .drv_req_i(drv_req_i), .pwm_on_i(pwm_on_i),
    .oc_hit_i(oc_hit_i), .hot_i(hot_i), .drv_o(drv_o), .fault_n_o(fault_n_o)
  );

  // {drv_req[3:0], oc pulse, expected fault_n, expected drv[3:0]}
  localparam logic [9:0] VEC [0:7] = '{
    10'b0101_1_1_0101, 10'b1010_0_1_1010, 10'b1111_1_1_1111, 10'b0000_0_1_0000,
    10'b1001_1_1_1001, 10'b0110_0_1_0110, 10'b0001_1_1_0001, 10'b1000_0_1_1000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwm_on_i = 1'b0; oc_hit_i = 1'b0; hot_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; drv_req_i = '1; pwm_on_i = 1'b0; oc_hit_i = 1'b0; hot_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 reset drive off", drv_o, 0);
    check("R2 reset fault released", fault_n_o, 1);
    do_reset();

    // Table walk: pass-through with isolated comparator pulses
    for (int i = 0; i < 8; i++) begin
      drv_req_i = VEC[i][9:6];
      oc_hit_i  = VEC[i][5];
      @(negedge clk);
      check("R1 table drive", drv_o, VEC[i][3:0]);
      check("R8 table single pulse no trip", fault_n_o, VEC[i][4]);
    end
    oc_hit_i = 1'b0;

    // Overheat trips and sticks
    drv_req_i = 4'hF;
    hot_i = 1'b1;
    #1 check("R1 before edge still passes", drv_o, 4'hF);
    @(negedge clk);
    check("R3 overheat trips", fault_n_o, 0);
    check("R4 drive forced off", drv_o, 0);
    hot_i = 1'b0; drv_req_i = 4'h6;
    repeat (5) @(negedge clk);
    check("R5 latch sticky", fault_n_o, 0);
    check("R4 drive stays off", drv_o, 0);

    // Reset clears
    do_reset();
    check("R5 reset clears latch", fault_n_o, 1);
    check("R1 pass after clear", drv_o, 4'h6);

    // Filter: 1,0,1 no trip, then held high trips on 2nd edge
    oc_hit_i = 1'b1; @(negedge clk);
    oc_hit_i = 1'b0; @(negedge clk);
    oc_hit_i = 1'b1; @(negedge clk);
    check("R8 count restarted by low", fault_n_o, 1);
    @(negedge clk);
    check("R8 two consecutive trips", fault_n_o, 0);
    check("R4 drive off after oc", drv_o, 0);

    // Blanking window
    do_reset();
    pwm_on_i = 1'b1; oc_hit_i = 1'b1;
    repeat (11) @(negedge clk);
    check("R6 no trip through window", fault_n_o, 1);
    @(negedge clk);
    check("R6 trip after window plus filter", fault_n_o, 0);

    // Retrigger
    do_reset();
    pwm_on_i = 1'b1; oc_hit_i = 1'b1;
    repeat (5) @(negedge clk);
    pwm_on_i = 1'b0;
    @(negedge clk);
    pwm_on_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 original window end no trip", fault_n_o, 1);
    repeat (5) @(negedge clk);
    check("R7 restarted window no trip", fault_n_o, 1);
    @(negedge clk);
    check("R7 trip after restarted window", fault_n_o, 0);

    // Overheat inside blanking
    do_reset();
    pwm_on_i = 1'b1; hot_i = 1'b1;
    @(negedge clk);
    check("R3 overheat not blanked", fault_n_o, 0);

    // Overheat held through reset
    @(negedge clk);
    rst_n = 1'b0; drv_req_i = 4'hF;
    repeat (3) @(negedge clk);
    check("R2 latch held clear in reset", fault_n_o, 1);
    check("R2 drive off in reset", drv_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 overheat after reset release", fault_n_o, 0);

    finish_run();
  end

endmodule